// File: doc/BRIEF.md
# Staged Reset Sequencer with Cause Latch

This block is the reset controller of a small microcontroller. It collects reset requests from power-up, a supply-monitor comparator, the illegal-instruction logic and the unmapped-fetch logic, and it watches an open-drain reset pin that it can also pull low. Every request runs the same recovery sequence. The pin is pulled low and the core clocks are gated through an oscillator settling window. After that window ends, the pin is released at one offset and the core is let go at a later offset.

A five-flag cause latch records why the chip was reset. Flags from successive resets collect until software reads the status byte, and that one read empties the latch. A short time after the controller lets go of the pin, it samples the pin. If something outside is still holding it low, the external-pin cause is added to the latch.

Top module: `reset_sequencer`

## Requirements
- R1: While `por` is high and directly after it falls, `sts_rdata` is 0x80 (only bit 7, the power-up flag, set), `core_clk_hold` and `rst_pin_drive` are 1 and `core_run` is 0.
- R2: After a request is taken at a clock edge, `core_clk_hold` and `rst_pin_drive` stay 1 for exactly SETTLE_CYC cycles. For a supply event, this window counts from the edge where `lv_low` is first seen low again.
- R3: `rst_pin_drive` falls PIN_REL_OFS cycles after the settling window ends, and `core_run` rises CORE_REL_OFS cycles after it ends.
- R4: While `lv_low` is 1, `core_clk_hold` and `rst_pin_drive` are 1 and `core_run` is 0 for as long as the supply stays low. A supply event sets status bit 1.
- R5: A one-cycle `op_illegal` sets status bit 4 and starts a sequence. A `stop_exec` with `cfg_stop_en` at 0 does the same. A `stop_exec` with `cfg_stop_en` at 1 has no effect.
- R6: `bus_unmapped` together with `bus_opfetch` sets status bit 3 and starts a sequence. `bus_unmapped` with `bus_opfetch` at 0 has no effect.
- R7: Flags from several resets accumulate. A cycle with `sts_rd` high returns the current flags and clears all of them at the next edge. Bits 5, 2 and 0 always read 0.
- R8: A cause that arrives in the same cycle as a read survives the clear.
- R9: PIN_SAMPLE_OFS cycles after the controller releases the pin, the pin is sampled. If it is low, status bit 6 is set in addition to the flags already held.
- R10: A low level on `rst_pin_in` while the core runs starts a new sequence and sets status bit 6.
- R11: A request that arrives while a sequence is in progress restarts the settling window from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por | input | 1 | Power-up reset, active high, asynchronous |
| lv_low | input | 1 | Supply-monitor output, 1 while the supply is below threshold |
| op_illegal | input | 1 | One-cycle pulse for an undefined opcode |
| stop_exec | input | 1 | One-cycle pulse when a stop instruction executes |
| cfg_stop_en | input | 1 | 1 permits the stop instruction |
| bus_unmapped | input | 1 | Current bus address hits no mapped region |
| bus_opfetch | input | 1 | Current bus cycle is an opcode fetch |
| rst_pin_in | input | 1 | Sensed level of the reset pin |
| rst_pin_drive | output | 1 | 1 pulls the reset pin low |
| core_clk_hold | output | 1 | 1 gates the clocks to the core and peripherals |
| core_run | output | 1 | 1 lets the core start its reset-vector fetch |
| sts_rd | input | 1 | Status read strobe, one cycle |
| sts_rdata | output | 8 | Status byte, valid in the cycle of `sts_rd` |

## Verification
The assertions assume that `rst_pin_in` is already synchronous to `clk`, and that it reads low whenever `rst_pin_drive` is 1, as an open-drain pin would. The bench models the pin as a wire-AND of the controller's drive and an external holder. All request strobes change just after a clock edge, so each one is seen at exactly one edge. The "no effect" assertions assume that no other cause is active in the same cycle, and the bench pulses each ignored stimulus alone while the core is running.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        PH_LOWV   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_STAGE  = 2'd2,
        PH_RUN    = 2'd3
    } phase_e;

    // cause vector positions
    localparam int FL_LVI  = 0;
    localparam int FL_ILAD = 1;
    localparam int FL_ILOP = 2;
    localparam int FL_PIN  = 3;
    localparam int FL_POR  = 4;
    localparam int FL_N    = 5;

    // status byte positions
    localparam int SB_POR  = 7;
    localparam int SB_PIN  = 6;
    localparam int SB_ILOP = 4;
    localparam int SB_ILAD = 3;
    localparam int SB_LVI  = 1;

    function automatic logic [7:0] pack_status(input logic [FL_N-1:0] f);
        logic [7:0] b;
        b          = '0;
        b[SB_POR]  = f[FL_POR];
        b[SB_PIN]  = f[FL_PIN];
        b[SB_ILOP] = f[FL_ILOP];
        b[SB_ILAD] = f[FL_ILAD];
        b[SB_LVI]  = f[FL_LVI];
        return b;
    endfunction

endpackage

// File: rtl/rstseq_req.sv
module rstseq_req
    import rstseq_pkg::*;
(
    input  logic            lv_low,
    input  logic            lowv_phase,
    input  logic            running,
    input  logic            sample_pt,
    input  logic            op_illegal,
    input  logic            stop_exec,
    input  logic            cfg_stop_en,
    input  logic            bus_unmapped,
    input  logic            bus_opfetch,
    input  logic            rst_pin_in,
    output logic [FL_N-1:0] set_vec,
    output logic            restart
);

    logic ilop_hit;
    logic ilad_hit;
    logic ext_hit;

    always_comb begin
        ilop_hit = op_illegal || (stop_exec && !cfg_stop_en);
        ilad_hit = bus_unmapped && bus_opfetch;
        ext_hit  = running && !rst_pin_in;

        set_vec          = '0;
        set_vec[FL_LVI]  = lv_low && !lowv_phase;
        set_vec[FL_ILOP] = ilop_hit;
        set_vec[FL_ILAD] = ilad_hit;
        set_vec[FL_PIN]  = ext_hit || (sample_pt && !rst_pin_in);
        restart          = ilop_hit || ilad_hit || ext_hit;
    end

endmodule

// File: rtl/rstseq_phase.sv
module rstseq_phase
    import rstseq_pkg::*;
#(
    parameter int SETTLE_CYC     = 4096,
    parameter int PIN_REL_OFS    = 32,
    parameter int CORE_REL_OFS   = 64,
    parameter int PIN_SAMPLE_OFS = 32
) (
    input  logic clk,
    input  logic por,
    input  logic lv_low,
    input  logic restart,
    output logic clk_hold,
    output logic pin_drive,
    output logic core_run,
    output logic running,
    output logic lowv_phase,
    output logic sample_pt
);

    localparam int SAMPLE_AT  = PIN_REL_OFS + PIN_SAMPLE_OFS;
    localparam int STAGE_LAST = (CORE_REL_OFS > SAMPLE_AT) ? CORE_REL_OFS : SAMPLE_AT;
    localparam int CNT_MAX    = (SETTLE_CYC - 1 > STAGE_LAST) ? SETTLE_CYC - 1 : STAGE_LAST;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.ph)
            PH_LOWV: begin
                if (!lv_low) begin
                    seq_d.ph  = PH_SETTLE;
                    seq_d.cnt = '0;
                end
            end
            PH_SETTLE: begin
                if (seq_q.cnt == CNT_W'(SETTLE_CYC - 1)) begin
                    seq_d.ph  = PH_STAGE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_STAGE: begin
                if (seq_q.cnt == CNT_W'(STAGE_LAST)) begin
                    seq_d.ph  = PH_RUN;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d = seq_q;
        endcase
        if (lv_low) begin
            seq_d.ph  = PH_LOWV;
            seq_d.cnt = '0;
        end else if (restart) begin
            seq_d.ph  = PH_SETTLE;
            seq_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            seq_q.ph  <= PH_SETTLE;
            seq_q.cnt <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        lowv_phase = (seq_q.ph == PH_LOWV);
        clk_hold   = lowv_phase || (seq_q.ph == PH_SETTLE);
        pin_drive  = clk_hold ||
                     ((seq_q.ph == PH_STAGE) && (seq_q.cnt < CNT_W'(PIN_REL_OFS)));
        running    = (seq_q.ph == PH_RUN);
        core_run   = running ||
                     ((seq_q.ph == PH_STAGE) && (seq_q.cnt >= CNT_W'(CORE_REL_OFS)));
        sample_pt  = (seq_q.ph == PH_STAGE) && (seq_q.cnt == CNT_W'(SAMPLE_AT));
    end

    AST_HOLD_KEEPS_PIN: assert property (@(posedge clk) disable iff (por)
        clk_hold |-> pin_drive); // R2
    AST_STAGE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (por)
        (seq_q.ph == PH_STAGE && seq_q.cnt == '0) |-> $past(seq_q.ph) == PH_SETTLE); // R2
    AST_CORE_AFTER_PIN: assert property (@(posedge clk) disable iff (por)
        core_run |-> !pin_drive); // R3
    AST_LOWV_HOLDS: assert property (@(posedge clk) disable iff (por)
        lv_low |=> (clk_hold && !core_run)); // R4
    AST_RESTART_WINDOW: assert property (@(posedge clk) disable iff (por)
        (restart && !lv_low) |=> (clk_hold && pin_drive && !core_run)); // R11

endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
    import rstseq_pkg::*;
(
    input  logic            clk,
    input  logic            por,
    input  logic [FL_N-1:0] set_vec,
    input  logic            sts_rd,
    output logic [7:0]      sts_rdata
);

    logic [FL_N-1:0] flags_d, flags_q;

    always_comb begin
        flags_d   = (sts_rd ? '0 : flags_q) | set_vec;
        sts_rdata = pack_status(flags_q);
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            flags_q         <= '0;
            flags_q[FL_POR] <= 1'b1;
        end else begin
            flags_q <= flags_d;
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (por)
        (sts_rdata & 8'h25) == 8'h00); // R7
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (por)
        !sts_rd |=> (flags_q & $past(flags_q)) == $past(flags_q)); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (por)
        (sts_rd && set_vec == '0) |=> flags_q == '0); // R7
    AST_NEW_CAUSE_KEPT: assert property (@(posedge clk) disable iff (por)
        sts_rd |=> (flags_q & $past(set_vec)) == $past(set_vec)); // R8

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int SETTLE_CYC     = 4096,
    parameter int PIN_REL_OFS    = 32,
    parameter int CORE_REL_OFS   = 64,
    parameter int PIN_SAMPLE_OFS = 32
) (
    input  logic       clk,
    input  logic       por,
    input  logic       lv_low,
    input  logic       op_illegal,
    input  logic       stop_exec,
    input  logic       cfg_stop_en,
    input  logic       bus_unmapped,
    input  logic       bus_opfetch,
    input  logic       rst_pin_in,
    output logic       rst_pin_drive,
    output logic       core_clk_hold,
    output logic       core_run,
    input  logic       sts_rd,
    output logic [7:0] sts_rdata
);

    logic            running;
    logic            lowv_phase;
    logic            sample_pt;
    logic            restart;
    logic [FL_N-1:0] set_vec;

    rstseq_req u_req (
        .lv_low       (lv_low),
        .lowv_phase   (lowv_phase),
        .running      (running),
        .sample_pt    (sample_pt),
        .op_illegal   (op_illegal),
        .stop_exec    (stop_exec),
        .cfg_stop_en  (cfg_stop_en),
        .bus_unmapped (bus_unmapped),
        .bus_opfetch  (bus_opfetch),
        .rst_pin_in   (rst_pin_in),
        .set_vec      (set_vec),
        .restart      (restart)
    );

    rstseq_phase #(
        .SETTLE_CYC     (SETTLE_CYC),
        .PIN_REL_OFS    (PIN_REL_OFS),
        .CORE_REL_OFS   (CORE_REL_OFS),
        .PIN_SAMPLE_OFS (PIN_SAMPLE_OFS)
    ) u_phase (
        .clk        (clk),
        .por        (por),
        .lv_low     (lv_low),
        .restart    (restart),
        .clk_hold   (core_clk_hold),
        .pin_drive  (rst_pin_drive),
        .core_run   (core_run),
        .running    (running),
        .lowv_phase (lowv_phase),
        .sample_pt  (sample_pt)
    );

    rstseq_cause u_cause (
        .clk       (clk),
        .por       (por),
        .set_vec   (set_vec),
        .sts_rd    (sts_rd),
        .sts_rdata (sts_rdata)
    );

    AST_STOP_PERMITTED: assert property (@(posedge clk) disable iff (por)
        (running && stop_exec && cfg_stop_en && !op_illegal && !bus_opfetch &&
         !lv_low && rst_pin_in) |=> core_run); // R5
    AST_DATA_UNMAPPED_HARMLESS: assert property (@(posedge clk) disable iff (por)
        (running && bus_unmapped && !bus_opfetch && !op_illegal && !stop_exec &&
         !lv_low && rst_pin_in) |=> core_run); // R6
    AST_EXT_PIN_RESTARTS: assert property (@(posedge clk) disable iff (por)
        (running && !rst_pin_in) |=> (core_clk_hold && !core_run)); // R10

endmodule

// File: tb/tb_reset_sequencer.sv
`timescale 1ns/1ps
module tb_reset_sequencer;

    localparam int SETTLE = 4096;
    localparam int PREL   = 32;
    localparam int CREL   = 64;
    localparam int PSMP   = 32;
    localparam int SEQLEN = SETTLE + CREL + 10;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic lv_low = 0, op_illegal = 0, stop_exec = 0, cfg_stop_en = 0;
    logic bus_unmapped = 0, bus_opfetch = 0, sts_rd = 0, ext_low = 0;
    logic rst_pin_drive, core_clk_hold, core_run;
    logic [7:0] sts_rdata;
    wire  rst_pin_in = !(rst_pin_drive || ext_low);

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        int    at;
        int    sel;
        int    val;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    reset_sequencer #(
        .SETTLE_CYC(SETTLE), .PIN_REL_OFS(PREL),
        .CORE_REL_OFS(CREL), .PIN_SAMPLE_OFS(PSMP)
    ) dut (
        .clk(clk), .por(por), .lv_low(lv_low), .op_illegal(op_illegal),
        .stop_exec(stop_exec), .cfg_stop_en(cfg_stop_en),
        .bus_unmapped(bus_unmapped), .bus_opfetch(bus_opfetch),
        .rst_pin_in(rst_pin_in), .rst_pin_drive(rst_pin_drive),
        .core_clk_hold(core_clk_hold), .core_run(core_run),
        .sts_rd(sts_rd), .sts_rdata(sts_rdata)
    );

    function automatic int observe(input int sel);
        case (sel)
            0: return int'(core_clk_hold);
            1: return int'(rst_pin_drive);
            2: return int'(core_run);
            default: return int'(sts_rdata);
        endcase
    endfunction

    // monitor: compare due scoreboard items between edges
    always @(negedge clk) begin
        int i;
        i = 0;
        while (i < sb.size()) begin
            if (sb[i].at <= cyc) begin
                checks++;
                if (sb[i].at < cyc || observe(sb[i].sel) != sb[i].val) begin
                    errors++;
                    $display("FAIL %s cyc=%0d sel=%0d actual=0x%0h expected=0x%0h",
                             sb[i].tag, cyc, sb[i].sel, observe(sb[i].sel), sb[i].val);
                end
                sb.delete(i);
            end else begin
                i++;
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) tick();
    endtask

    task automatic push(input int at, input int sel, input int val, input string tag);
        exp_t e;
        e.at = at; e.sel = sel; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    // window shape after a request taken at edge b (R2, R3)
    task automatic expect_seq(input int b);
        push(b,                 0, 1, "R2 hold start");
        push(b,                 1, 1, "R2 pin low start");
        push(b + SETTLE - 1,    0, 1, "R2 hold last");
        push(b + SETTLE,        0, 0, "R2 hold end");
        push(b + SETTLE + PREL - 1, 1, 1, "R3 pin still low");
        push(b + SETTLE + PREL, 1, 0, "R3 pin released");
        push(b + SETTLE + CREL - 1, 2, 0, "R3 core still held");
        push(b + SETTLE + CREL, 2, 1, "R3 core released");
    endtask

    task automatic rd_expect(input int val, input string tag);
        tick();
        sts_rd = 1;
        push(cyc, 3, val, tag);
        tick();
        sts_rd = 0;
    endtask

    task automatic pulse_ilop(output int b);
        tick();
        op_illegal = 1;
        b = cyc + 1;
        tick();
        op_illegal = 0;
    endtask

    initial begin
        int b;
        int b2;
        int c;
        repeat (3) tick();
        por = 0;
        b = cyc;
        // R1 reset state
        push(b, 3, 8'h80, "R1 status");
        push(b, 2, 0,     "R1 core held");
        expect_seq(b);
        wait_until(b + SEQLEN);
        rd_expect(8'h80, "R1 power-up flag");
        rd_expect(8'h00, "R7 cleared");

        // R5 illegal opcode then R6 opcode fetch unmapped: accumulation R7
        pulse_ilop(b);
        expect_seq(b);
        wait_until(b + SEQLEN);
        tick();
        bus_unmapped = 1; bus_opfetch = 1;
        b = cyc + 1;
        expect_seq(b);
        tick();
        bus_unmapped = 0; bus_opfetch = 0;
        wait_until(b + SEQLEN);
        rd_expect(8'h18, "R7 ilop+ilad accumulate");
        rd_expect(8'h00, "R7 all cleared");

        // R5 permitted stop: no effect
        tick();
        stop_exec = 1; cfg_stop_en = 1;
        c = cyc;
        push(c + 1, 2, 1, "R5 permitted stop run");
        push(c + 2, 2, 1, "R5 permitted stop run");
        push(c + 2, 0, 0, "R5 permitted stop no hold");
        tick();
        stop_exec = 0;
        // R6 data access to unmapped: no effect
        bus_unmapped = 1;
        c = cyc;
        push(c + 1, 2, 1, "R6 data access run");
        push(c + 2, 0, 0, "R6 data access no hold");
        tick();
        bus_unmapped = 0;
        wait_until(c + 5);
        rd_expect(8'h00, "R6 no flag from data access");

        // R5 forbidden stop
        tick();
        stop_exec = 1; cfg_stop_en = 0;
        b = cyc + 1;
        expect_seq(b);
        tick();
        stop_exec = 0;
        wait_until(b + SEQLEN);
        rd_expect(8'h10, "R5 forbidden stop sets bit4");

        // R4 low supply
        tick();
        lv_low = 1;
        c = cyc;
        push(c + 1,  0, 1, "R4 hold in low supply");
        push(c + 1,  2, 0, "R4 core held");
        push(c + 90, 0, 1, "R4 hold persists");
        push(c + 90, 1, 1, "R4 pin low persists");
        wait_until(c + 100);
        lv_low = 0;
        b = c + 101;
        expect_seq(b);
        wait_until(b + SEQLEN);
        rd_expect(8'h02, "R4 supply flag");

        // R10 external assertion while running
        tick();
        ext_low = 1;
        b = cyc + 1;
        expect_seq(b);
        repeat (3) tick();
        ext_low = 0;
        wait_until(b + SEQLEN);
        rd_expect(8'h40, "R10 pin flag");

        // R9 pin held past the sample point
        pulse_ilop(b);
        wait_until(b + 100);
        ext_low = 1;
        push(b + SETTLE + PREL + 2, 1, 0, "R9 drive released");
        wait_until(b + SETTLE + PREL + PSMP + 1);
        ext_low = 0;
        wait_until(b + SEQLEN);
        rd_expect(8'h50, "R9 pin flag added");

        // R11 restart during a sequence
        pulse_ilop(b);
        wait_until(b + 999);
        bus_unmapped = 1; bus_opfetch = 1;
        b2 = cyc + 1;
        tick();
        bus_unmapped = 0; bus_opfetch = 0;
        push(b + SETTLE, 0, 1, "R11 old window cancelled");
        push(b + SETTLE + CREL, 2, 0, "R11 core not released early");
        expect_seq(b2);
        wait_until(b2 + SEQLEN);

        // R8 cause in the read cycle survives
        tick();
        sts_rd = 1; op_illegal = 1;
        b = cyc + 1;
        push(cyc, 3, 8'h18, "R8 read data before clear");
        tick();
        sts_rd = 0; op_illegal = 0;
        expect_seq(b);
        wait_until(b + SEQLEN);
        rd_expect(8'h10, "R8 new cause kept");
        rd_expect(8'h00, "R7 cleared again");

        repeat (3) tick();
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1 unchecked items actual=%0d expected=0", sb.size());
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule